// File: doc/BRIEF.md
# Buffered SPI Host Controller

This block is a memory-mapped SPI host. Software programs a control word, a 9-bit clock divider and the serial word size, then queues outgoing words through the data register. A shift engine drains the transmit queue one word at a time, most significant bit first, on a serial clock derived from the input clock. Each word shifted in is placed in a receive queue, which software drains by reading the data register. Every register can be written whole, or bit by bit through separate set and clear addresses, so software can change a single field without a read-modify-write sequence.

Both queues hold 16 bytes, so their capacity in words depends on the word size. The status register reports both fill levels and a sticky flag that records a received word lost to a full receive queue. The serial clock can run in any of the four polarity and phase modes, and the receive sample can be taken in the middle or at the end of a bit time. When enabled, the slave-select output is driven by the block itself: it stays low while any word is queued or shifting.

Software sees back-pressure only through the level fields. A data write that finds the transmit queue full is dropped. A received word that finds the receive queue full is dropped and raises the overflow flag. Software is expected to poll the levels before it writes or reads.

Top module: `spi_host_ctrl`

## Requirements
- R1: Each half period of `sclk` lasts DIV+1 input clock cycles, where DIV is the 9-bit baud register. A raw write keeps only its low 9 bits.
- R2: `reg_addr[3:2]` selects the register (0 control, 1 status, 2 data, 3 baud). `reg_addr[1:0]` selects the access (0 raw, 1 clear, 2 set, 3 none). A clear write zeroes every bit written as 1, and a set write sets every bit written as 1. Reads through any address other than raw return 0. Only a raw write to the data register queues a word.
- R3: Control bit positions: host enable 5, idle clock level 6, edge select 8, late sample 9, word size 11:10 (0 is 8 bits, 1 is 16 bits, 2 is 32 bits, 3 acts as 8 bits), module enable 15, deep queue 16, automatic select 28. All other control bits read 0, and every register resets to 0.
- R4: A word of the selected size is sent MSB first with exactly that many idle-to-active `sclk` transitions. The word received in the same period reads back right-aligned with zero upper bits.
- R5: Queue capacity in words is 16, 8 or 4 for 8-, 16- or 32-bit words with deep queue set, and 1 with it clear. A data write to a full transmit queue is dropped.
- R6: Status bits 20:16 hold the transmit level and bits 28:24 hold the receive level. Status bit 6 is the overflow flag.
- R7: A received word that arrives while the receive queue is full is discarded and sets the overflow flag. The flag stays set through raw and set writes, and is cleared only by a clear write with bit 6 set.
- R8: While no word is shifting, `sclk` equals the idle level. With edge select 1, `mosi` changes on the active-to-idle transition. With edge select 0, it changes on the idle-to-active transition. A loopback of `mosi` into `miso` returns the sent word with late sample set or clear.
- R9: With automatic select, module enable and host enable all set, `ss_n` is low while a word is queued or shifting, and it does not rise between back-to-back queued words. With automatic select clear, `ss_n` stays high.
- R10: While module enable is clear, the shift engine stops, both queues are empty, `sclk` rests at its idle level, and the other register contents are kept.
- R11: Shifting starts only while module enable and host enable are set and the transmit queue is not empty. A raw read of the data register returns the oldest received word and removes it. Reading an empty queue returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the source of the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue on a raw data read) |
| reg_addr | input | 4 | Register select [3:2] and access type [1:0] |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address, valid in the same cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select under automatic control |

## Verification
A bad word size or shift counter shows up within one word as a wrong count of `sclk` transitions, and as a wrong word in the loopback read. A queue pointer or level error shows up in the next status read as a wrong level or a wrong capacity. A divider off by one changes the spacing between clock transitions within the first bit. A flag or select output that is not held shows up the first time it is needed: the overflow bit after a raw status write, or a rise of `ss_n` in the idle cycle between two queued words.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int RSEL_CTRL = 0;
  localparam int RSEL_STAT = 1;
  localparam int RSEL_DATA = 2;
  localparam int RSEL_BAUD = 3;
  localparam int ACC_RAW = 0;
  localparam int ACC_CLR = 1;
  localparam int ACC_SET = 2;

  localparam int CB_HOST   = 5;
  localparam int CB_CKP    = 6;
  localparam int CB_CKE    = 8;
  localparam int CB_SMP    = 9;
  localparam int CB_WS     = 10;
  localparam int CB_ON     = 15;
  localparam int CB_DEEP   = 16;
  localparam int CB_AUTOSS = 28;

  localparam int SB_OVF = 6;
  localparam int SB_TXL = 16;
  localparam int SB_RXL = 24;

  localparam int DIV_W = 9;

  localparam logic [31:0] CTRL_MASK = (32'd1 << CB_HOST) | (32'd1 << CB_CKP) |
      (32'd1 << CB_CKE) | (32'd1 << CB_SMP) | (32'd3 << CB_WS) | (32'd1 << CB_ON) |
      (32'd1 << CB_DEEP) | (32'd1 << CB_AUTOSS);

  typedef enum logic [1:0] {WS_8 = 2'd0, WS_16 = 2'd1, WS_32 = 2'd2, WS_ALT = 2'd3} wsize_e;

  function automatic logic [5:0] ws_bits(input logic [1:0] ws);
    case (ws)
      WS_16:   return 6'd16;
      WS_32:   return 6'd32;
      default: return 6'd8;
    endcase
  endfunction

  function automatic logic [1:0] ws_log2_bytes(input logic [1:0] ws);
    case (ws)
      WS_16:   return 2'd1;
      WS_32:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [31:0] ws_mask(input logic [1:0] ws);
    case (ws)
      WS_16:   return 32'h0000_FFFF;
      WS_32:   return 32'hFFFF_FFFF;
      default: return 32'h0000_00FF;
    endcase
  endfunction
endpackage

// File: rtl/spi_host_fifo.sv
module spi_host_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [LW-1:0] cap,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (level >= cap);
  assign empty   = (level == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign rdata   = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      level <= level + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int LW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [3:0]       addr,
  input  logic [31:0]      wdata,
  input  logic [LW-1:0]    tx_level,
  input  logic [LW-1:0]    rx_level,
  input  logic [31:0]      rx_head,
  input  logic             rx_empty,
  input  logic             rx_drop,
  output logic [31:0]      ctrl,
  output logic [DIV_W-1:0] div,
  output logic             ovf,
  output logic             tx_push,
  output logic             rx_pop,
  output logic [31:0]      rdata
);
  logic [1:0] rsel, acc;
  logic       wr_ctrl, wr_baud, ovf_clr;
  logic [31:0] status;

  assign rsel    = addr[3:2];
  assign acc     = addr[1:0];
  assign wr_ctrl = wr && (rsel == 2'(RSEL_CTRL));
  assign wr_baud = wr && (rsel == 2'(RSEL_BAUD));
  assign ovf_clr = wr && (rsel == 2'(RSEL_STAT)) && (acc == 2'(ACC_CLR)) && wdata[SB_OVF];
  assign tx_push = wr && (rsel == 2'(RSEL_DATA)) && (acc == 2'(ACC_RAW)) && ctrl[CB_ON];
  assign rx_pop  = rd && (rsel == 2'(RSEL_DATA)) && (acc == 2'(ACC_RAW)) && !rx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      div  <= '0;
      ovf  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        case (acc)
          2'(ACC_RAW): ctrl <= wdata & CTRL_MASK;
          2'(ACC_SET): ctrl <= ctrl | (wdata & CTRL_MASK);
          2'(ACC_CLR): ctrl <= ctrl & ~wdata;
          default:     ctrl <= ctrl;
        endcase
      end
      if (wr_baud) begin
        case (acc)
          2'(ACC_RAW): div <= wdata[DIV_W-1:0];
          2'(ACC_SET): div <= div | wdata[DIV_W-1:0];
          2'(ACC_CLR): div <= div & ~wdata[DIV_W-1:0];
          default:     div <= div;
        endcase
      end
      if (rx_drop)      ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  always_comb begin
    status = '0;
    status[SB_OVF] = ovf;
    status[SB_TXL +: LW] = tx_level;
    status[SB_RXL +: LW] = rx_level;
  end

  always_comb begin
    rdata = '0;
    if (acc == 2'(ACC_RAW)) begin
      case (rsel)
        2'(RSEL_CTRL): rdata = ctrl;
        2'(RSEL_STAT): rdata = status;
        2'(RSEL_DATA): rdata = rx_empty ? 32'd0 : rx_head;
        default:       rdata = {{(32-DIV_W){1'b0}}, div};
      endcase
    end
  end
endmodule

// File: rtl/spi_host_baud.sv
module spi_host_baud
  import spi_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!en)  cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/spi_host_shift.sv
module spi_host_shift
  import spi_host_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        on,
  input  logic        go,
  input  logic        smp,
  input  logic [1:0]  ws,
  input  logic        tx_empty,
  input  logic [31:0] tx_head,
  input  logic        tick,
  input  logic        miso,
  output logic        tx_pop,
  output logic        busy,
  output logic        half,
  output logic        rx_push,
  output logic [31:0] rx_word,
  output logic        mosi
);
  logic [31:0] tx_sh, rx_sh, rx_next;
  logic [4:0]  bitc;
  logic [1:0]  ws_q;
  logic [5:0]  width_q;
  logic        last_bit;

  assign width_q  = ws_bits(ws_q);
  assign last_bit = ({1'b0, bitc} == width_q - 6'd1);
  assign tx_pop   = !busy && go && !tx_empty;
  assign rx_next  = {rx_sh[30:0], miso};
  assign rx_push  = busy && tick && half && last_bit;
  assign rx_word  = (smp ? rx_next : rx_sh) & ws_mask(ws_q);
  assign mosi     = busy && tx_sh[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      half  <= 1'b0;
      bitc  <= '0;
      ws_q  <= '0;
      tx_sh <= '0;
      rx_sh <= '0;
    end else if (!on) begin
      busy <= 1'b0;
      half <= 1'b0;
      bitc <= '0;
    end else if (!busy) begin
      if (tx_pop) begin
        busy  <= 1'b1;
        half  <= 1'b0;
        bitc  <= '0;
        ws_q  <= ws;
        tx_sh <= tx_head << (6'd32 - ws_bits(ws));
        rx_sh <= '0;
      end
    end else if (tick) begin
      if (!half) begin
        half <= 1'b1;
        if (!smp) rx_sh <= rx_next;
      end else begin
        half <= 1'b0;
        if (smp) rx_sh <= rx_next;
        if (last_bit) begin
          busy <= 1'b0;
        end else begin
          bitc  <= bitc + 5'd1;
          tx_sh <= tx_sh << 1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int QBYTES = 16,
  localparam int DEPTH = QBYTES,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        ss_n
);
  logic [31:0]      ctrl;
  logic [DIV_W-1:0] div;
  logic             ovf_flag;
  logic             ctl_on, ctl_host, ctl_ckp, ctl_cke, ctl_smp, ctl_deep, ctl_autoss;
  logic [1:0]       ctl_ws;
  logic [LW-1:0]    fifo_cap, tx_level, rx_level;
  logic             tx_push, tx_pop, tx_full, tx_empty;
  logic             rx_pop, rx_full, rx_empty, eng_rx_push, rx_drop;
  logic [31:0]      tx_head, rx_head, rx_word;
  logic             eng_busy, eng_half, tick;

  assign ctl_on     = ctrl[CB_ON];
  assign ctl_host   = ctrl[CB_HOST];
  assign ctl_ckp    = ctrl[CB_CKP];
  assign ctl_cke    = ctrl[CB_CKE];
  assign ctl_smp    = ctrl[CB_SMP];
  assign ctl_deep   = ctrl[CB_DEEP];
  assign ctl_autoss = ctrl[CB_AUTOSS];
  assign ctl_ws     = ctrl[CB_WS +: 2];

  assign fifo_cap = ctl_deep ? LW'(DEPTH >> ws_log2_bytes(ctl_ws)) : LW'(1);
  assign rx_drop  = eng_rx_push && rx_full;

  spi_host_regs #(.LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .tx_level(tx_level), .rx_level(rx_level), .rx_head(rx_head),
    .rx_empty(rx_empty), .rx_drop(rx_drop), .ctrl(ctrl), .div(div), .ovf(ovf_flag),
    .tx_push(tx_push), .rx_pop(rx_pop), .rdata(reg_rdata)
  );

  spi_host_fifo #(.DW(32), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(!ctl_on), .cap(fifo_cap), .push(tx_push),
    .wdata(reg_wdata), .pop(tx_pop), .rdata(tx_head), .level(tx_level),
    .full(tx_full), .empty(tx_empty)
  );

  spi_host_fifo #(.DW(32), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(!ctl_on), .cap(fifo_cap), .push(eng_rx_push),
    .wdata(rx_word), .pop(rx_pop), .rdata(rx_head), .level(rx_level),
    .full(rx_full), .empty(rx_empty)
  );

  spi_host_baud u_baud (
    .clk(clk), .rst_n(rst_n), .en(eng_busy), .div(div), .tick(tick)
  );

  spi_host_shift u_eng (
    .clk(clk), .rst_n(rst_n), .on(ctl_on), .go(ctl_on && ctl_host), .smp(ctl_smp),
    .ws(ctl_ws), .tx_empty(tx_empty), .tx_head(tx_head), .tick(tick), .miso(miso),
    .tx_pop(tx_pop), .busy(eng_busy), .half(eng_half), .rx_push(eng_rx_push),
    .rx_word(rx_word), .mosi(mosi)
  );

  assign sclk = ctl_ckp ^ (eng_busy && (ctl_cke ? eng_half : !eng_half));
  assign ss_n = !(ctl_autoss && ctl_on && ctl_host && (eng_busy || !tx_empty));

  logic unused_ok;
  assign unused_ok = tx_full;
endmodule

// File: rtl/spi_host_ctrl_chk.sv
module spi_host_ctrl_chk #(
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [3:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          on,
  input logic          host,
  input logic          autoss,
  input logic          ckp,
  input logic          busy,
  input logic          rx_push,
  input logic          ovf,
  input logic          sclk,
  input logic          ss_n,
  input logic [LW-1:0] cap,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level
);
  AST_IDLE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == ckp); // R8
  AST_OFF_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> (tx_level == '0 && rx_level == '0 && !busy)); // R10
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(on && host)); // R11
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (on && rx_push && rx_level >= cap) |=> ovf); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(reg_wr && reg_addr == 4'b0101 && reg_wdata[6])) |=> ovf); // R7
  AST_AUTO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (autoss && on && host && busy) |-> !ss_n); // R9
endmodule

bind spi_host_ctrl spi_host_ctrl_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .on(ctl_on), .host(ctl_host), .autoss(ctl_autoss), .ckp(ctl_ckp), .busy(eng_busy),
  .rx_push(eng_rx_push), .ovf(ovf_flag), .sclk(sclk), .ss_n(ss_n), .cap(fifo_cap),
  .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/sim_spi_host_ctrl.sv
module sim_spi_host_ctrl;
  localparam int R_CTRL = 0, R_STAT = 1, R_DATA = 2, R_BAUD = 3;
  localparam int A_RAW = 0, A_CLR = 1, A_SET = 2;
  localparam logic [31:0] HOST = 32'h20, ON = 32'h8000, DEEP = 32'h1_0000, AUTO = 32'h1000_0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, reg_wr, reg_rd, miso;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  wire  [31:0] reg_rdata;
  wire         sclk, mosi, ss_n;
  assign miso = mosi;

  spi_host_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .ss_n(ss_n)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // line monitor, sampled away from the active edge
  logic        m_ckp = 0, m_cke = 0, prev_sclk = 0, prev_ss = 1;
  int          cyc = 0, leads = 0, last_lead = 0, gap = 0, ss_rise = 0, ss_fall = 0;
  logic [31:0] cap_word = 0;

  always @(negedge clk) begin
    cyc++;
    if (sclk !== prev_sclk) begin
      if (sclk != m_ckp) begin
        leads++;
        if (last_lead != 0) gap = cyc - last_lead;
        last_lead = cyc;
      end
      if ((sclk != m_ckp) == m_cke) cap_word = {cap_word[30:0], mosi};
    end
    if (ss_n && !prev_ss) ss_rise++;
    if (!ss_n && prev_ss) ss_fall++;
    prev_sclk = sclk;
    prev_ss = ss_n;
  end

  task automatic mon_clear();
    leads = 0; last_lead = 0; gap = 0; cap_word = 0; ss_rise = 0; ss_fall = 0;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(int r, int a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = {r[1:0], a[1:0]}; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(int r, int a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = {r[1:0], a[1:0]};
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic wait_rx(int n, string req);
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(R_STAT, A_RAW, s);
      if (((s >> 24) & 31) == n) return;
    end
    check(req, (s >> 24) & 31, n);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(R_CTRL, A_RAW, v); check("R3 ctrl reset", v, 0);
    rd(R_STAT, A_RAW, v); check("R3 status reset", v, 0);
    rd(R_BAUD, A_RAW, v); check("R3 baud reset", v, 0);
    check("R8 sclk reset idle", {31'd0, sclk}, 0);
    check("R9 ss_n reset", {31'd0, ss_n}, 1);
  endtask

  task automatic t_alias();
    logic [31:0] v;
    wr(R_BAUD, A_RAW, 32'h0F0);
    wr(R_BAUD, A_SET, 32'h00F);
    rd(R_BAUD, A_RAW, v); check("R2 set alias", v, 32'h0FF);
    wr(R_BAUD, A_CLR, 32'h0F0);
    rd(R_BAUD, A_RAW, v); check("R2 clear alias", v, 32'h00F);
    rd(R_BAUD, A_SET, v); check("R2 alias read zero", v, 0);
    wr(R_BAUD, A_RAW, 32'hFFFF_FFFF);
    rd(R_BAUD, A_RAW, v); check("R1 divider 9 bits", v, 32'h1FF);
    wr(R_CTRL, A_RAW, 32'hFFFF_FFFF);
    rd(R_CTRL, A_RAW, v); check("R3 ctrl implemented bits", v, 32'h1001_8F60);
    wr(R_CTRL, A_RAW, ON);
    wr(R_DATA, A_SET, 32'h55);
    rd(R_STAT, A_RAW, v); check("R2 alias data write ignored", v, 0);
    wr(R_CTRL, A_RAW, 0);
  endtask

  task automatic t_xfer(bit ckp, bit cke, bit smp, int ws, logic [31:0] d, int dv);
    logic [31:0] v, m;
    int w;
    w = (ws == 1) ? 16 : (ws == 2) ? 32 : 8;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    wr(R_BAUD, A_RAW, dv);
    m_ckp = ckp; m_cke = cke;
    wr(R_CTRL, A_RAW, ON | HOST | DEEP | (32'(ckp) << 6) | (32'(cke) << 8) |
       (32'(smp) << 9) | (32'(ws) << 10));
    idle(2);
    check("R8 idle level", {31'd0, sclk}, {31'd0, ckp});
    mon_clear();
    wr(R_DATA, A_RAW, d);
    wait_rx(1, "R4 word received");
    check("R4 edge count", leads, w);
    check("R4 msb first on line", cap_word & m, d & m);
    check("R1 leading edge spacing", gap, 2 * (dv + 1));
    check("R9 ss stays high without auto", ss_fall, 0);
    rd(R_DATA, A_RAW, v); check("R8 loopback word", v, d & m);
    rd(R_DATA, A_RAW, v); check("R11 empty read", v, 0);
    wr(R_CTRL, A_RAW, 0);
  endtask

  task automatic t_capacity();
    logic [31:0] v;
    int ws_l[3] = '{2, 1, 0};
    int exp_l[3] = '{4, 8, 16};
    for (int k = 0; k < 3; k++) begin
      wr(R_CTRL, A_RAW, ON | DEEP | (32'(ws_l[k]) << 10));
      for (int i = 0; i < 18; i++) wr(R_DATA, A_RAW, i);
      rd(R_STAT, A_RAW, v); check("R5 R6 deep capacity", v, 32'(exp_l[k]) << 16);
      wr(R_CTRL, A_RAW, 0);
    end
    wr(R_CTRL, A_RAW, ON);
    for (int i = 0; i < 3; i++) wr(R_DATA, A_RAW, i);
    rd(R_STAT, A_RAW, v); check("R5 shallow capacity", v, 32'd1 << 16);
    wr(R_CTRL, A_RAW, 0);
  endtask

  task automatic t_off_flush();
    logic [31:0] v;
    wr(R_CTRL, A_RAW, ON | DEEP | AUTO | (32'd1 << 6));
    for (int i = 0; i < 3; i++) wr(R_DATA, A_RAW, 32'h10 + i);
    rd(R_STAT, A_RAW, v); check("R10 levels before", v, 32'd3 << 16);
    wr(R_CTRL, A_CLR, ON);
    rd(R_STAT, A_RAW, v); check("R10 flushed", v, 0);
    rd(R_CTRL, A_RAW, v); check("R10 ctrl kept", v, DEEP | AUTO | (32'd1 << 6));
    check("R10 sclk idle", {31'd0, sclk}, 1);
    wr(R_CTRL, A_RAW, ON | HOST);
    idle(40);
    rd(R_STAT, A_RAW, v); check("R11 nothing sent after flush", v, 0);
    wr(R_CTRL, A_RAW, 0);
  endtask

  task automatic t_auto_ss();
    logic [31:0] v;
    wr(R_BAUD, A_RAW, 1);
    m_ckp = 0; m_cke = 1;
    wr(R_CTRL, A_RAW, ON | HOST | DEEP | AUTO | (32'd1 << 8));
    idle(2);
    mon_clear();
    wr(R_DATA, A_RAW, 32'hC3);
    wr(R_DATA, A_RAW, 32'h3C);
    wait_rx(2, "R9 two words");
    idle(3);
    check("R9 ss fell once", ss_fall, 1);
    check("R9 ss rose once", ss_rise, 1);
    check("R9 ss high after", {31'd0, ss_n}, 1);
    rd(R_DATA, A_RAW, v); check("R11 first word", v, 32'hC3);
    rd(R_DATA, A_RAW, v); check("R11 second word", v, 32'h3C);
    wr(R_CTRL, A_RAW, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    wr(R_BAUD, A_RAW, 0);
    m_ckp = 0; m_cke = 1;
    wr(R_CTRL, A_RAW, ON | HOST | DEEP | (32'd1 << 8));
    for (int i = 0; i < 16; i++) wr(R_DATA, A_RAW, 32'hA0 + i);
    wait_rx(16, "R7 queue filled");
    rd(R_STAT, A_RAW, v); check("R7 no flag at capacity", v, 32'd16 << 24);
    wr(R_DATA, A_RAW, 32'h77);
    idle(40);
    rd(R_STAT, A_RAW, v); check("R7 flag after drop", v, (32'd16 << 24) | 32'h40);
    wr(R_STAT, A_RAW, 0);
    wr(R_STAT, A_SET, 0);
    rd(R_STAT, A_RAW, v); check("R7 raw write keeps flag", v & 32'h40, 32'h40);
    rd(R_DATA, A_RAW, v); check("R7 oldest kept", v, 32'hA0);
    wr(R_STAT, A_CLR, 32'h40);
    rd(R_STAT, A_RAW, v); check("R7 clear alias", v, 32'd15 << 24);
    wr(R_CTRL, A_RAW, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    idle(3);
    rst_n = 1;
    idle(2);
    t_reset();
    t_alias();
    t_xfer(0, 1, 0, 0, 32'hA5, 1);
    t_xfer(0, 0, 0, 0, 32'h6B, 1);
    t_xfer(1, 1, 0, 0, 32'h81, 1);
    t_xfer(1, 0, 0, 0, 32'h3E, 1);
    t_xfer(0, 1, 1, 0, 32'hD2, 0);
    t_xfer(1, 0, 1, 1, 32'h1234_BEEF, 3);
    t_xfer(0, 1, 0, 2, 32'hDEAD_5A0F, 0);
    t_xfer(1, 1, 1, 3, 32'hFF5C, 2);
    t_capacity();
    t_off_flush();
    t_auto_ss();
    t_overflow();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule